// File: doc/BRIEF.md
# DDR2 Command Bus Decoder

This block watches the command pins of a DDR2 SDRAM interface and turns each rising clock edge into one classified command. It is meant for a controller-side monitor or a memory model front end: the sampled clock-enable, chip-select, row/column strobes, write enable, bank and address pins come in, and a registered command code comes out. Alongside the code it gives the target bank and a decoded address field: the row, the column, or the mode opcode.

Clock enable is kept from one edge to the next. This lets the decoder tell an ordinary refresh from a self-refresh entry, and a power-down entry from an exit. A small power-state register records whether the device is active, powered down or in self refresh. It shows the two low-power states as level outputs, so a refresh-interval monitor can pause while no refresh can happen. A burst guard flags any read or write that cuts into a running four-beat burst. An illegal-command pulse marks bus misuse around low-power transitions, reserved encodings and writes to undefined mode registers.

All outputs are registered. The result for the pins sampled at edge N is visible from edge N until edge N+1.

Top module: `ddr2_cmd_decoder`

## Requirements
- R1: While rst_ni is low, cmd_o is 0 (NONE), bank_o, addr_o, ap_o, pd_o, sr_o, illegal_o and burst_viol_o are 0, and the stored clock enable is taken as high.
- R2: With CKE high at the previous and current edge, cs_n high gives cmd_o=1 (DESELECT), and cs_n low with ras_n, cas_n, we_n all high gives cmd_o=2 (NOP). Results appear one edge after sampling.
- R3: Pins {cs_n,ras_n,cas_n,we_n}=0011 with CKE high in both cycles give cmd_o=11 (ACTIVATE), with bank_o=ba_i and addr_o=a_i (the row).
- R4: Pins 0100 give cmd_o=12 (WRITE) and 0101 give cmd_o=13 (READ). bank_o=ba_i, ap_o=a_i[10], and addr_o holds the column {a_i[13:11],a_i[9:0]} with its top bit 0. ap_o is high only on READ or WRITE.
- R5: Pins 0010 give cmd_o=9 (single-bank PRECHARGE, bank_o=ba_i) when a_i[10]=0, and cmd_o=10 (PRECHARGE ALL, bank_o=0) when a_i[10]=1. addr_o is 0 in both cases.
- R6: Pins 0000 give cmd_o=3 (LOAD MODE), with bank_o=ba_i as the register select and addr_o=a_i as the opcode. A select of 4 or more also pulses illegal_o for that one cycle.
- R7: Pins 0001 with CKE high in both cycles give cmd_o=4 (REFRESH). The same pins with CKE falling give cmd_o=5 (SELF-REFRESH entry) and set sr_o.
- R8: CKE falling while the bus is DESELECT or NOP gives cmd_o=7 (POWER-DOWN entry) and sets pd_o.
- R9: CKE rising gives cmd_o=6 (SELF-REFRESH exit) if sr_o was set and cmd_o=8 (POWER-DOWN exit) otherwise, and clears pd_o and sr_o. pd_o and sr_o are never high together.
- R10: While CKE is low at both the previous and the current edge, the command pins are ignored: cmd_o=0, no burst starts, and the power state is kept.
- R11: illegal_o pulses for one cycle when CKE falls with a bus that is neither DESELECT, NOP nor refresh (this still counts as POWER-DOWN entry), when CKE rises with a bus that is not DESELECT or NOP (the exit still happens), and for the reserved pins 0110 with CKE high (cmd_o=0).
- R12: A READ or WRITE decoded before the previous READ or WRITE burst has completed (BURST_CYCLES edges, default 2) raises burst_viol_o with that command and restarts the burst. burst_viol_o is high only with READ or WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable pin |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank address pins |
| a_i | input | ADDR_W | Address pins |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BA_W | Target bank or mode register select |
| addr_o | output | ADDR_W | Row, column or mode opcode |
| ap_o | output | 1 | Auto-precharge on READ/WRITE |
| pd_o | output | 1 | Device in power-down |
| sr_o | output | 1 | Device in self refresh |
| illegal_o | output | 1 | One-cycle illegal command pulse |
| burst_viol_o | output | 1 | One-cycle burst interruption pulse |

## Verification
The hardest cases to reach are those where the same rising CKE edge must decode as two different exits, and where illegal pins arrive on an entry or exit edge. Both outcomes depend on state left behind by an earlier transition, not on the pins of the current cycle. The stimulus therefore walks the bus through full sequences: refresh, then self-refresh entry, then idle cycles with live-looking read pins under low CKE, then exit. It does the same for power-down, and then repeats power-down with an ACTIVATE pattern on the falling edge and a READ pattern on the rising edge. It also issues back-to-back and spaced column commands to find the exact edge at which a burst is free again.

// File: rtl/ddr2_cmd_pkg.sv
package ddr2_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_NONE    = 4'd0,
    CMD_DESEL   = 4'd1,
    CMD_NOP     = 4'd2,
    CMD_MODE    = 4'd3,
    CMD_REF     = 4'd4,
    CMD_SR_IN   = 4'd5,
    CMD_SR_OUT  = 4'd6,
    CMD_PD_IN   = 4'd7,
    CMD_PD_OUT  = 4'd8,
    CMD_PRE     = 4'd9,
    CMD_PRE_ALL = 4'd10,
    CMD_ACT     = 4'd11,
    CMD_WR      = 4'd12,
    CMD_RD      = 4'd13
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_DOWN   = 2'd1,
    PWR_SELF   = 2'd2
  } pwr_e;
endpackage

// File: rtl/ddr2_cmd_classify.sv
module ddr2_cmd_classify
  import ddr2_cmd_pkg::*;
(
  input  logic cke_prev_i,
  input  logic cke_i,
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  input  logic a10_i,
  input  pwr_e pwr_i,
  output cmd_e cmd_o,
  output pwr_e pwr_nxt_o,
  output logic bad_o
);
  logic bus_idle, ref_pat;

  assign bus_idle = cs_n_i | (ras_n_i & cas_n_i & we_n_i);
  assign ref_pat  = ~cs_n_i & ~ras_n_i & ~cas_n_i & we_n_i;

  always_comb begin
    cmd_o     = CMD_NONE;
    pwr_nxt_o = pwr_i;
    bad_o     = 1'b0;
    case ({cke_prev_i, cke_i})
      2'b11: begin
        if (cs_n_i) begin
          cmd_o = CMD_DESEL;
        end else begin
          case ({ras_n_i, cas_n_i, we_n_i})
            3'b000: cmd_o = CMD_MODE;
            3'b001: cmd_o = CMD_REF;
            3'b010: cmd_o = a10_i ? CMD_PRE_ALL : CMD_PRE;
            3'b011: cmd_o = CMD_ACT;
            3'b100: cmd_o = CMD_WR;
            3'b101: cmd_o = CMD_RD;
            3'b110: bad_o = 1'b1;  // reserved encoding
            default: cmd_o = CMD_NOP;
          endcase
        end
      end
      2'b10: begin
        if (ref_pat) begin
          cmd_o     = CMD_SR_IN;
          pwr_nxt_o = PWR_SELF;
        end else begin
          cmd_o     = CMD_PD_IN;
          pwr_nxt_o = PWR_DOWN;
          bad_o     = ~bus_idle;
        end
      end
      2'b01: begin
        cmd_o     = (pwr_i == PWR_SELF) ? CMD_SR_OUT : CMD_PD_OUT;
        pwr_nxt_o = PWR_ACTIVE;
        bad_o     = ~bus_idle;
      end
      default: cmd_o = CMD_NONE;  // CKE held low: pins ignored
    endcase
  end
endmodule

// File: rtl/ddr2_addr_decode.sv
module ddr2_addr_decode
  import ddr2_cmd_pkg::*;
#(
  parameter int BA_W   = 3,
  parameter int ADDR_W = 14,
  parameter int AP_BIT = 10,
  parameter int NUM_MR = 4
) (
  input  cmd_e              cmd_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] a_i,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ap_o,
  output logic              mr_bad_o
);
  localparam logic [BA_W:0] MR_LIM = (BA_W+1)'(NUM_MR);

  logic [ADDR_W-2:0] col;
  assign col = {a_i[ADDR_W-1:AP_BIT+1], a_i[AP_BIT-1:0]};

  always_comb begin
    bank_o   = '0;
    addr_o   = '0;
    ap_o     = 1'b0;
    mr_bad_o = 1'b0;
    case (cmd_i)
      CMD_ACT: begin
        bank_o = ba_i;
        addr_o = a_i;
      end
      CMD_RD, CMD_WR: begin
        bank_o = ba_i;
        addr_o = {1'b0, col};
        ap_o   = a_i[AP_BIT];
      end
      CMD_PRE: bank_o = ba_i;
      CMD_MODE: begin
        bank_o   = ba_i;
        addr_o   = a_i;
        mr_bad_o = ({1'b0, ba_i} >= MR_LIM);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr2_burst_guard.sv
module ddr2_burst_guard #(
  parameter int BURST_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic viol_o
);
  generate
    if (BURST_CYCLES > 1) begin : g_cnt
      localparam int CNT_W = $clog2(BURST_CYCLES);
      logic [CNT_W-1:0] left_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           left_q <= '0;
        else if (start_i)      left_q <= CNT_W'(BURST_CYCLES - 1);
        else if (left_q != '0) left_q <= left_q - 1'b1;
      end

      assign viol_o = start_i && (left_q != '0);
    end else begin : g_none
      assign viol_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ddr2_cmd_decoder.sv
module ddr2_cmd_decoder
  import ddr2_cmd_pkg::*;
#(
  parameter int BA_W         = 3,
  parameter int ADDR_W       = 14,
  parameter int NUM_MR       = 4,
  parameter int BURST_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_n_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] a_i,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ap_o,
  output logic              pd_o,
  output logic              sr_o,
  output logic              illegal_o,
  output logic              burst_viol_o
);
  localparam int AP_BIT = 10;

  logic cke_q;
  pwr_e pwr_q, pwr_nxt;
  cmd_e cmd_w, cmd_q;
  logic bad_w, mr_bad_w, ap_w, viol_w;
  logic [BA_W-1:0]   bank_w, bank_q;
  logic [ADDR_W-1:0] addr_w, addr_q;
  logic ap_q, ill_q, viol_q;

  ddr2_cmd_classify u_classify (
    .cke_prev_i (cke_q),
    .cke_i      (cke_i),
    .cs_n_i     (cs_n_i),
    .ras_n_i    (ras_n_i),
    .cas_n_i    (cas_n_i),
    .we_n_i     (we_n_i),
    .a10_i      (a_i[AP_BIT]),
    .pwr_i      (pwr_q),
    .cmd_o      (cmd_w),
    .pwr_nxt_o  (pwr_nxt),
    .bad_o      (bad_w)
  );

  ddr2_addr_decode #(
    .BA_W   (BA_W),
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT),
    .NUM_MR (NUM_MR)
  ) u_addr (
    .cmd_i    (cmd_w),
    .ba_i     (ba_i),
    .a_i      (a_i),
    .bank_o   (bank_w),
    .addr_o   (addr_w),
    .ap_o     (ap_w),
    .mr_bad_o (mr_bad_w)
  );

  ddr2_burst_guard #(.BURST_CYCLES(BURST_CYCLES)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i ((cmd_w == CMD_RD) || (cmd_w == CMD_WR)),
    .viol_o  (viol_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q  <= 1'b1;
      pwr_q  <= PWR_ACTIVE;
      cmd_q  <= CMD_NONE;
      bank_q <= '0;
      addr_q <= '0;
      ap_q   <= 1'b0;
      ill_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      cke_q  <= cke_i;
      pwr_q  <= pwr_nxt;
      cmd_q  <= cmd_w;
      bank_q <= bank_w;
      addr_q <= addr_w;
      ap_q   <= ap_w;
      ill_q  <= bad_w | mr_bad_w;
      viol_q <= viol_w;
    end
  end

  assign cmd_o        = cmd_q;
  assign bank_o       = bank_q;
  assign addr_o       = addr_q;
  assign ap_o         = ap_q;
  assign pd_o         = (pwr_q == PWR_DOWN);
  assign sr_o         = (pwr_q == PWR_SELF);
  assign illegal_o    = ill_q;
  assign burst_viol_o = viol_q;
endmodule

// File: rtl/ddr2_cmd_decoder_chk.sv
module ddr2_cmd_decoder_chk #(
  parameter int BURST_CYCLES = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cke_i,
  input logic [3:0] cmd_o,
  input logic       ap_o,
  input logic       pd_o,
  input logic       sr_o,
  input logic       burst_viol_o
);
  logic [1:0] age_q;
  logic       col_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign col_cmd = (cmd_o == 4'd12) || (cmd_o == 4'd13);

  assert_pwr_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pd_o, sr_o}));

  assert_pd_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 4'd7) |-> pd_o);

  assert_sr_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 4'd5) |-> sr_o);

  assert_ap_col_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_o |-> col_cmd);

  assert_viol_col_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_viol_o |-> col_cmd);

  assert_cke_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !$past(cke_i) && !$past(cke_i, 2)) |-> (cmd_o == 4'd0));

  generate
    if (BURST_CYCLES > 1) begin : g_b2b
      assert_back2back_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && col_cmd && ($past(cmd_o) == 4'd12 || $past(cmd_o) == 4'd13))
          |-> burst_viol_o);
    end
  endgenerate
endmodule

bind ddr2_cmd_decoder ddr2_cmd_decoder_chk #(.BURST_CYCLES(BURST_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cke_i        (cke_i),
  .cmd_o        (cmd_o),
  .ap_o         (ap_o),
  .pd_o         (pd_o),
  .sr_o         (sr_o),
  .burst_viol_o (burst_viol_o)
);

// File: tb/ddr2_cmd_decoder_bench.sv
module ddr2_cmd_decoder_bench;
  localparam logic [3:0] P_DESEL = 4'b1111, P_NOP = 4'b0111, P_MRS = 4'b0000,
                         P_REF = 4'b0001, P_PRE = 4'b0010, P_ACT = 4'b0011,
                         P_WR = 4'b0100, P_RD = 4'b0101, P_RSV = 4'b0110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0]  ba = '0;
  logic [13:0] a = '0;
  logic [3:0]  cmd;
  logic [2:0]  bank;
  logic [13:0] addr;
  logic ap, pd, sr, ill, viol;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ddr2_cmd_decoder u_ddr2_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .a_i(a), .cmd_o(cmd),
    .bank_o(bank), .addr_o(addr), .ap_o(ap), .pd_o(pd), .sr_o(sr),
    .illegal_o(ill), .burst_viol_o(viol)
  );

  // drive at negedge, sample 1 ns after the capturing edge
  task automatic cyc(input logic k, input logic [3:0] p, input logic [2:0] b, input logic [13:0] ad);
    @(negedge clk);
    cke = k; {cs_n, ras_n, cas_n, we_n} = p; ba = b; a = ad;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [3:0] ec, input logic [2:0] eb,
                     input logic [13:0] ea, input logic eap, input logic epd,
                     input logic esr, input logic eill, input logic eviol);
    logic [26:0] act, exp;
    act = {cmd, bank, addr, ap, pd, sr, ill, viol};
    exp = {ec, eb, ea, eap, epd, esr, eill, eviol};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual cmd=%0d bank=%0d addr=%h ap=%b pd=%b sr=%b ill=%b viol=%b expected cmd=%0d bank=%0d addr=%h ap=%b pd=%b sr=%b ill=%b viol=%b",
               req, cmd, bank, addr, ap, pd, sr, ill, viol, ec, eb, ea, eap, epd, esr, eill, eviol);
    end
  endtask

  task automatic t_reset;
    chk("R1", 4'd0, 3'd0, 14'h0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_idle;
    cyc(1, P_DESEL, 3'd4, 14'h1234); chk("R2", 4'd1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, P_NOP, 3'd2, 14'h0F0F);   chk("R2", 4'd2, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_act;
    cyc(1, P_ACT, 3'd5, 14'h2ABC); chk("R3", 4'd11, 3'd5, 14'h2ABC, 0, 0, 0, 0, 0);
  endtask

  task automatic t_rdwr;
    cyc(1, P_WR, 3'd2, 14'h2C05); chk("R4", 4'd12, 3'd2, 14'h1405, 1, 0, 0, 0, 0);
    cyc(1, P_NOP, 0, 0);
    cyc(1, P_NOP, 0, 0);
    cyc(1, P_RD, 3'd7, 14'h0123); chk("R4", 4'd13, 3'd7, 14'h0123, 0, 0, 0, 0, 0);
    cyc(1, P_NOP, 0, 0);
    cyc(1, P_NOP, 0, 0);
  endtask

  task automatic t_pre;
    cyc(1, P_PRE, 3'd3, 14'h0000); chk("R5", 4'd9, 3'd3, 0, 0, 0, 0, 0, 0);
    cyc(1, P_PRE, 3'd3, 14'h0400); chk("R5", 4'd10, 3'd0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_mode;
    cyc(1, P_MRS, 3'd1, 14'h0432); chk("R6", 4'd3, 3'd1, 14'h0432, 0, 0, 0, 0, 0);
    cyc(1, P_MRS, 3'd6, 14'h0055); chk("R6", 4'd3, 3'd6, 14'h0055, 0, 0, 0, 1, 0);
    cyc(1, P_NOP, 0, 0);           chk("R6", 4'd2, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_sref;
    cyc(1, P_REF, 0, 0);           chk("R7", 4'd4, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, P_REF, 0, 0);           chk("R7", 4'd5, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, P_RD, 3'd1, 14'h0010);  chk("R10", 4'd0, 0, 0, 0, 0, 1, 0, 0);
    cyc(1, P_NOP, 0, 0);           chk("R9", 4'd6, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, P_NOP, 0, 0);           chk("R9", 4'd2, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_pd;
    cyc(0, P_NOP, 0, 0);           chk("R8", 4'd7, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, P_WR, 3'd2, 14'h0400);  chk("R10", 4'd0, 0, 0, 0, 1, 0, 0, 0);
    cyc(1, P_DESEL, 0, 0);         chk("R9", 4'd8, 0, 0, 0, 0, 0, 0, 0);
    // a READ right after the ignored WRITE pins must not see a running burst
    cyc(1, P_RD, 3'd0, 14'h0001);  chk("R10", 4'd13, 0, 14'h0001, 0, 0, 0, 0, 0);
    cyc(1, P_NOP, 0, 0);
    cyc(1, P_NOP, 0, 0);
  endtask

  task automatic t_illegal;
    cyc(0, P_ACT, 3'd1, 14'h0011); chk("R11", 4'd7, 0, 0, 0, 1, 0, 1, 0);
    cyc(0, P_DESEL, 0, 0);         chk("R11", 4'd0, 0, 0, 0, 1, 0, 0, 0);
    cyc(1, P_RD, 3'd2, 14'h0400);  chk("R11", 4'd8, 0, 0, 0, 0, 0, 1, 0);
    cyc(1, P_RSV, 0, 0);           chk("R11", 4'd0, 0, 0, 0, 0, 0, 1, 0);
    cyc(1, P_NOP, 0, 0);           chk("R11", 4'd2, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_burst;
    cyc(1, P_RD, 3'd1, 14'h0008);  chk("R12", 4'd13, 3'd1, 14'h0008, 0, 0, 0, 0, 0);
    cyc(1, P_RD, 3'd1, 14'h0010);  chk("R12", 4'd13, 3'd1, 14'h0010, 0, 0, 0, 0, 1);
    cyc(1, P_NOP, 0, 0);           chk("R12", 4'd2, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, P_WR, 3'd0, 14'h0020);  chk("R12", 4'd12, 0, 14'h0020, 0, 0, 0, 0, 0);
    cyc(1, P_WR, 3'd0, 14'h0404);  chk("R12", 4'd12, 0, 14'h0004, 1, 0, 0, 0, 1);
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_idle();
    t_act();
    t_rdwr();
    t_pre();
    t_mode();
    t_sref();
    t_pd();
    t_illegal();
    t_burst();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule